// File: doc/BRIEF.md
# DMA Descriptor List Address Walker

This block steps a DMA engine through a list of four-word descriptors held in memory. Each descriptor carries its own linkage choice. A chained descriptor names its single data buffer in word 2 and the address of the following descriptor in word 3. A ring descriptor names two data buffers in words 2 and 3, and the following descriptor sits at a fixed stride after it. That stride is 16 bytes plus a programmable gap, given in words.

Once enabled, the walker reads the four words of the current descriptor through a simple request/response port, one word at a time. It then presents the descriptor address, the buffer address or addresses and the linkage mode. The walker holds this until the consumer signals that the buffers are used up. It then computes the next descriptor address, pulses a strobe with that address and fetches the next descriptor. In ring mode, an end-of-list flag sends the pointer back to the list base. A synchronous restart reloads the pointer from the base at any time.

Top module: `dma_desc_walker`

## Requirements
- R1: After reset the block is idle: `rd_req`, `desc_ready` and `next_valid` are all 0.
- R2: When `enable` rises from idle, the block captures `list_base` with bits [1:0] forced to 0, together with `skip_len` and `rx_list`. It then reads the descriptor at that address as four word-aligned requests, at offsets +0, +4, +8 and +12, one request at a time. When the fourth word arrives, `desc_ready` goes to 1 and `cur_addr` shows the descriptor address.
- R3: The chain flag is bit 20 of word 0 for a transmit list (`rx_list`=0) and bit 14 of word 1 for a receive list (`rx_list`=1). A chained descriptor gives `chain_mode`=1, `buf1_addr`= word 2 (any byte alignment), `buf2_valid`=0, and a next address equal to word 3 with bits [1:0] cleared.
- R4: A ring descriptor gives `chain_mode`=0, `buf1_addr`= word 2 and `buf2_addr`= word 3, with `buf2_valid`=1. Its next address is the current address plus 16 plus 4×skip.
- R5: The end-of-list flag is bit 21 of word 0 for transmit and bit 15 of word 1 for receive. On a ring descriptor with this flag set, the next address is the captured list base.
- R6: On a chained descriptor the end-of-list flag is ignored, and the next address still comes from word 3.
- R7: The pointer advances only when `desc_done` is high while `desc_ready` is 1. On the following cycle, `next_valid` pulses for one cycle, and `next_addr` equals the new `cur_addr`. A `desc_done` at any other time has no effect.
- R8: The skip length is held from the moment of enabling. Changes on `skip_len` have no effect until the block is enabled again.
- R9: `restart`, while `enable` is high, loads `cur_addr` and the captured base from `list_base` (bits [1:0] cleared) on the next clock. It also clears `desc_ready` and refetches from that address, without a `next_valid` pulse.
- R10: While `enable` is low the block returns to idle on the next clock, with `rd_req`=0 and `desc_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the walker; low returns it to idle |
| restart | input | 1 | Reload the pointer from `list_base` |
| rx_list | input | 1 | 1 = receive field positions, 0 = transmit |
| list_base | input | ADDR_W | First descriptor address of the list |
| skip_len | input | SKIP_W | Ring gap between descriptors, in words |
| desc_done | input | 1 | Buffers of the current descriptor are consumed |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | ADDR_W | Word-aligned read address |
| rd_ack | input | 1 | Read response valid, with `rd_data` |
| rd_data | input | 32 | Descriptor word returned |
| cur_addr | output | ADDR_W | Address of the current descriptor |
| desc_ready | output | 1 | Current descriptor fetched, fields valid |
| chain_mode | output | 1 | Current descriptor uses chained linkage |
| buf1_addr | output | ADDR_W | First buffer address |
| buf2_addr | output | ADDR_W | Second buffer address (ring only) |
| buf2_valid | output | 1 | `buf2_addr` is meaningful |
| next_valid | output | 1 | One-cycle pulse: pointer advanced |
| next_addr | output | ADDR_W | Address the pointer advanced to |

## Verification
Some properties are checked on every cycle: word alignment of each read request, no request while a descriptor is presented, and the single-cycle shape of the advance pulse. Also checked every cycle are a stable pointer in the absence of an accepted `desc_done` or a restart, the held skip length, the restart load and the idle return. The address arithmetic itself can only be shown by the bench's scenarios, which walk descriptor lists in memory. These are a transmit ring with a gap and a wrap, a transmit chain with a stray end-of-list flag, and a receive list that mixes both linkages and then restarts. The scenarios check each expected descriptor and each advance address, in order.

// File: rtl/dma_walk_pkg.sv
package dma_walk_pkg;
   localparam int DESC_WORDS   = 4;
   localparam int DATA_W       = 32;
   localparam int TX_CHAIN_BIT = 20;
   localparam int TX_EOL_BIT   = 21;
   localparam int RX_CHAIN_BIT = 14;
   localparam int RX_EOL_BIT   = 15;

   typedef enum logic [1:0] {
      WK_IDLE  = 2'd0,
      WK_FETCH = 2'd1,
      WK_READY = 2'd2
   } walk_state_t;
endpackage

// File: rtl/desc_fetch.sv
// Sequential word reader: one outstanding request, captures each word.
module desc_fetch #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int WORDS  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          go,
   input  logic                          clr,
   input  logic [ADDR_W-1:0]             desc_addr,
   output logic                          rd_req,
   output logic [ADDR_W-1:0]             rd_addr,
   input  logic                          rd_ack,
   input  logic [DATA_W-1:0]             rd_data,
   output logic [WORDS-1:0][DATA_W-1:0]  words,
   output logic                          last
);
   localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

   if (WORDS < 2) begin : g_bad_words
      $error("desc_fetch: WORDS must be at least 2");
   end

   logic [IDX_W-1:0] idx_q;
   logic             take;

   assign rd_req  = go;
   assign rd_addr = desc_addr + ADDR_W'({idx_q, 2'b00});
   assign take    = go && rd_ack;
   assign last    = take && (idx_q == IDX_W'(WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (clr) begin
         idx_q <= '0;
      end else if (take) begin
         idx_q <= last ? '0 : idx_q + 1'b1;
      end
   end

   for (genvar i = 0; i < WORDS; i++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (take && !clr && idx_q == IDX_W'(i)) begin
            word_q <= rd_data;
         end
      end
      assign words[i] = word_q;
   end
endmodule

// File: rtl/link_calc.sv
// Next-descriptor address from the control words and the linkage rules.
module link_calc
   import dma_walk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SKIP_W = 5
) (
   input  logic              rx_list,
   input  logic [DATA_W-1:0] w0,
   input  logic [DATA_W-1:0] w1,
   input  logic [DATA_W-1:0] w3,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [SKIP_W-1:0] skip_words,
   output logic              chain,
   output logic [ADDR_W-1:0] next_addr
);
   localparam int STRIDE_BYTES = DESC_WORDS * 4;

   logic              eol;
   logic [ADDR_W-1:0] ring_step;
   logic [ADDR_W-1:0] link_ptr;

   if (ADDR_W > DATA_W) begin : g_bad_width
      $error("link_calc: ADDR_W cannot exceed the descriptor word width");
   end

   assign chain     = rx_list ? w1[RX_CHAIN_BIT] : w0[TX_CHAIN_BIT];
   assign eol       = rx_list ? w1[RX_EOL_BIT]   : w0[TX_EOL_BIT];
   assign ring_step = cur_addr + ADDR_W'(STRIDE_BYTES) + ADDR_W'({skip_words, 2'b00});
   assign link_ptr  = {w3[ADDR_W-1:2], 2'b00};

   always_comb begin
      if (chain)    next_addr = link_ptr;
      else if (eol) next_addr = base_addr;
      else          next_addr = ring_step;
   end
endmodule

// File: rtl/dma_desc_walker.sv
module dma_desc_walker
   import dma_walk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SKIP_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              restart,
   input  logic              rx_list,
   input  logic [ADDR_W-1:0] list_base,
   input  logic [SKIP_W-1:0] skip_len,
   input  logic              desc_done,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_ack,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              desc_ready,
   output logic              chain_mode,
   output logic [ADDR_W-1:0] buf1_addr,
   output logic [ADDR_W-1:0] buf2_addr,
   output logic              buf2_valid,
   output logic              next_valid,
   output logic [ADDR_W-1:0] next_addr
);
   if (ADDR_W < 12 || ADDR_W > DATA_W) begin : g_bad_addr
      $error("dma_desc_walker: ADDR_W out of range");
   end
   if (SKIP_W < 1 || SKIP_W > 8) begin : g_bad_skip
      $error("dma_desc_walker: SKIP_W out of range");
   end

   walk_state_t                        state_q;
   logic [ADDR_W-1:0]                  cur_q, base_q, next_q;
   logic [SKIP_W-1:0]                  skip_q;
   logic                               rx_q, nv_q;
   logic [DESC_WORDS-1:0][DATA_W-1:0]  words;
   logic                               fetch_last, chain_raw;
   logic [ADDR_W-1:0]                  link_next, base_in;
   logic                               load_base;

   assign base_in   = {list_base[ADDR_W-1:2], 2'b00};
   assign load_base = enable && (restart || state_q == WK_IDLE);

   desc_fetch #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .WORDS  (DESC_WORDS)
   ) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (state_q == WK_FETCH),
      .clr       (!enable || restart),
      .desc_addr (cur_q),
      .rd_req    (rd_req),
      .rd_addr   (rd_addr),
      .rd_ack    (rd_ack),
      .rd_data   (rd_data),
      .words     (words),
      .last      (fetch_last)
   );

   link_calc #(
      .ADDR_W (ADDR_W),
      .SKIP_W (SKIP_W)
   ) u_link (
      .rx_list    (rx_q),
      .w0         (words[0]),
      .w1         (words[1]),
      .w3         (words[3]),
      .cur_addr   (cur_q),
      .base_addr  (base_q),
      .skip_words (skip_q),
      .chain      (chain_raw),
      .next_addr  (link_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WK_IDLE;
         cur_q   <= '0;
         base_q  <= '0;
         next_q  <= '0;
         skip_q  <= '0;
         rx_q    <= 1'b0;
         nv_q    <= 1'b0;
      end else begin
         nv_q <= 1'b0;
         if (!enable) begin
            state_q <= WK_IDLE;
         end else if (load_base) begin
            if (state_q == WK_IDLE) begin
               skip_q <= skip_len;
               rx_q   <= rx_list;
            end
            cur_q   <= base_in;
            base_q  <= base_in;
            state_q <= WK_FETCH;
         end else begin
            case (state_q)
               WK_FETCH: if (fetch_last) state_q <= WK_READY;
               WK_READY: if (desc_done) begin
                  cur_q   <= link_next;
                  next_q  <= link_next;
                  nv_q    <= 1'b1;
                  state_q <= WK_FETCH;
               end
               default: state_q <= WK_IDLE;
            endcase
         end
      end
   end

   assign cur_addr   = cur_q;
   assign desc_ready = (state_q == WK_READY);
   assign chain_mode = desc_ready && chain_raw;
   assign buf1_addr  = words[2][ADDR_W-1:0];
   assign buf2_addr  = chain_raw ? '0 : words[3][ADDR_W-1:0];
   assign buf2_valid = desc_ready && !chain_raw;
   assign next_valid = nv_q;
   assign next_addr  = next_q;
endmodule

// File: rtl/dma_desc_walker_chk.sv
module dma_desc_walker_chk #(
   parameter int ADDR_W = 32,
   parameter int SKIP_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              restart,
   input logic [ADDR_W-1:0] list_base,
   input logic              desc_done,
   input logic              rd_req,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              desc_ready,
   input logic              chain_mode,
   input logic              buf2_valid,
   input logic              next_valid,
   input logic [ADDR_W-1:0] next_addr,
   input logic [SKIP_W-1:0] skip_q
);
   AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> rd_addr[1:0] == 2'b00);                                   // R2
   AST_NO_REQ_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      desc_ready |-> !rd_req);                                             // R2
   AST_CHAIN_ONE_BUF: assert property (@(posedge clk) disable iff (!rst_n)
      chain_mode |-> !buf2_valid);                                         // R3
   AST_BUF2_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      buf2_valid |-> desc_ready);                                          // R4
   AST_ADVANCE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      next_valid |=> !next_valid);                                         // R7
   AST_ADVANCE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      next_valid |-> next_addr == cur_addr);                               // R7
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && (rd_req || desc_ready) && !restart && !(desc_done && desc_ready))
      |=> $stable(cur_addr));                                              // R7
   AST_SKIP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && (rd_req || desc_ready)) |=> $stable(skip_q));             // R8
   AST_RESTART_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && restart) |=>
      (cur_addr == {$past(list_base[ADDR_W-1:2]), 2'b00}) && !desc_ready); // R9
   AST_IDLE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!rd_req && !desc_ready));                               // R10
endmodule

bind dma_desc_walker dma_desc_walker_chk #(
   .ADDR_W (ADDR_W),
   .SKIP_W (SKIP_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .restart    (restart),
   .list_base  (list_base),
   .desc_done  (desc_done),
   .rd_req     (rd_req),
   .rd_addr    (rd_addr),
   .cur_addr   (cur_addr),
   .desc_ready (desc_ready),
   .chain_mode (chain_mode),
   .buf2_valid (buf2_valid),
   .next_valid (next_valid),
   .next_addr  (next_addr),
   .skip_q     (skip_q)
);

// File: tb/dma_desc_walker_bench.sv
module dma_desc_walker_bench;
   localparam int AW = 32;
   localparam int SW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0, restart = 1'b0, rx_list = 1'b0, desc_done = 1'b0;
   logic [AW-1:0] list_base = '0;
   logic [SW-1:0] skip_len = '0;
   logic          rd_req, rd_ack;
   logic [AW-1:0] rd_addr;
   logic [31:0]   rd_data;
   logic [AW-1:0] cur_addr, buf1_addr, buf2_addr, next_addr;
   logic          desc_ready, chain_mode, buf2_valid, next_valid;

   logic [31:0] mem [256];
   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   assign rd_ack  = rd_req;
   assign rd_data = mem[rd_addr[9:2]];

   dma_desc_walker #(.ADDR_W(AW), .SKIP_W(SW)) u_dma_desc_walker (
      .clk(clk), .rst_n(rst_n), .enable(enable), .restart(restart),
      .rx_list(rx_list), .list_base(list_base), .skip_len(skip_len),
      .desc_done(desc_done), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_ack(rd_ack), .rd_data(rd_data), .cur_addr(cur_addr),
      .desc_ready(desc_ready), .chain_mode(chain_mode), .buf1_addr(buf1_addr),
      .buf2_addr(buf2_addr), .buf2_valid(buf2_valid), .next_valid(next_valid),
      .next_addr(next_addr)
   );

   typedef struct {
      logic [31:0] cur, b1, b2;
      logic        b2v;
      string       tag;
   } dexp_t;
   typedef struct {
      logic [31:0] addr;
      string       tag;
   } nexp_t;

   dexp_t dq[$];
   nexp_t nq[$];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, w1, w2, w3);
      mem[a[9:2]]     = w0;
      mem[a[9:2] + 1] = w1;
      mem[a[9:2] + 2] = w2;
      mem[a[9:2] + 3] = w3;
   endtask

   task automatic exp_desc(input logic [31:0] a, b1, b2, input logic b2v, input string tag);
      dexp_t e;
      e.cur = a; e.b1 = b1; e.b2 = b2; e.b2v = b2v; e.tag = tag;
      dq.push_back(e);
   endtask

   task automatic exp_next(input logic [31:0] a, input string tag);
      nexp_t e;
      e.addr = a; e.tag = tag;
      nq.push_back(e);
   endtask

   task automatic wait_ready();
      do @(negedge clk); while (!desc_ready);
   endtask

   task automatic step(input int hold);
      wait_ready();
      desc_done = 1'b1;
      repeat (hold) @(negedge clk);
      desc_done = 1'b0;
   endtask

   // monitor: compares each presented descriptor and each advance
   logic rdy_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (desc_ready && !rdy_prev) begin
            if (dq.size() == 0) begin
               chk(1'b0, "R7 unexpected descriptor", cur_addr, 32'hFFFF_FFFF);
            end else begin
               dexp_t e;
               e = dq.pop_front();
               chk(cur_addr == e.cur, {e.tag, " cur_addr"}, cur_addr, e.cur);
               chk(buf1_addr == e.b1, {e.tag, " buf1_addr"}, buf1_addr, e.b1);
               chk(buf2_valid == e.b2v, {e.tag, " buf2_valid"}, 32'(buf2_valid), 32'(e.b2v));
               chk(chain_mode == !e.b2v, {e.tag, " chain_mode"}, 32'(chain_mode), 32'(!e.b2v));
               if (e.b2v) chk(buf2_addr == e.b2, {e.tag, " buf2_addr"}, buf2_addr, e.b2);
            end
         end
         if (next_valid) begin
            if (nq.size() == 0) begin
               chk(1'b0, "R7 unexpected advance", next_addr, 32'hFFFF_FFFF);
            end else begin
               nexp_t n;
               n = nq.pop_front();
               chk(next_addr == n.addr, {n.tag, " next_addr"}, next_addr, n.addr);
               chk(cur_addr == n.addr, {n.tag, " cur after advance"}, cur_addr, n.addr);
            end
         end
         rdy_prev = desc_ready;
      end
   end

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R7 watchdog act=timeout exp=finished");
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | i;
      // transmit ring, gap of 2 words
      put_desc(32'h100, 32'h0, 32'h0, 32'hA000_0001, 32'hA000_0102);
      put_desc(32'h118, 32'h0, 32'h0, 32'hA100_0003, 32'hA100_0204);
      put_desc(32'h130, 32'h1 << 21, 32'h0, 32'hA200_0005, 32'hA200_0006);
      // transmit chain, stray end-of-list flag on the first descriptor
      put_desc(32'h200, (32'h1 << 20) | (32'h1 << 21), 32'h0, 32'h1234_5671, 32'h0000_0243);
      put_desc(32'h240, 32'h1 << 20, 32'h0, 32'h1234_5682, 32'h0000_0200);
      // receive list, mixed linkage
      put_desc(32'h300, 32'h1 << 20, 32'h0, 32'h0000_00B0, 32'h0000_00B4);
      put_desc(32'h310, 32'h0, 32'h1 << 14, 32'h0000_00C1, 32'h0000_0380);
      put_desc(32'h380, 32'h0, 32'h1 << 15, 32'h0000_00D2, 32'h0000_00D3);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!rd_req, "R1 rd_req after reset", 32'(rd_req), 32'h0);
      chk(!desc_ready, "R1 desc_ready after reset", 32'(desc_ready), 32'h0);
      chk(!next_valid, "R1 next_valid after reset", 32'(next_valid), 32'h0);

      // scenario 1: transmit ring
      exp_desc(32'h100, 32'hA000_0001, 32'hA000_0102, 1'b1, "R2");
      exp_next(32'h118, "R4");
      exp_desc(32'h118, 32'hA100_0003, 32'hA100_0204, 1'b1, "R8");
      exp_next(32'h130, "R8");
      exp_desc(32'h130, 32'hA200_0005, 32'hA200_0006, 1'b1, "R4");
      exp_next(32'h100, "R5");
      exp_desc(32'h100, 32'hA000_0001, 32'hA000_0102, 1'b1, "R5");
      rx_list = 1'b0; skip_len = 5'd2; list_base = 32'h103; enable = 1'b1;
      @(negedge clk);
      skip_len = 5'd7;            // R8: must not change the stride
      step(1);
      step(1);
      step(3);                    // R7: extra desc_done cycles fall in fetch
      wait_ready();
      enable = 1'b0;
      @(negedge clk);
      chk(!rd_req && !desc_ready, "R10 idle after enable low",
          {30'h0, rd_req, desc_ready}, 32'h0);

      // scenario 2: transmit chain
      exp_desc(32'h200, 32'h1234_5671, 32'h0, 1'b0, "R6");
      exp_next(32'h240, "R6");
      exp_desc(32'h240, 32'h1234_5682, 32'h0, 1'b0, "R3");
      exp_next(32'h200, "R3");
      exp_desc(32'h200, 32'h1234_5671, 32'h0, 1'b0, "R3");
      skip_len = 5'd5; list_base = 32'h200; enable = 1'b1;
      step(1);
      step(1);
      wait_ready();
      enable = 1'b0;
      @(negedge clk);

      // scenario 3: receive list, then restart at a new base
      exp_desc(32'h300, 32'h0000_00B0, 32'h0000_00B4, 1'b1, "R4");
      exp_next(32'h310, "R4");
      exp_desc(32'h310, 32'h0000_00C1, 32'h0, 1'b0, "R3");
      exp_next(32'h380, "R3");
      exp_desc(32'h380, 32'h0000_00D2, 32'h0000_00D3, 1'b1, "R5");
      exp_next(32'h300, "R5");
      exp_desc(32'h300, 32'h0000_00B0, 32'h0000_00B4, 1'b1, "R5");
      exp_desc(32'h380, 32'h0000_00D2, 32'h0000_00D3, 1'b1, "R9");
      exp_next(32'h380, "R9");
      exp_desc(32'h380, 32'h0000_00D2, 32'h0000_00D3, 1'b1, "R9");
      rx_list = 1'b1; skip_len = 5'd0; list_base = 32'h300; enable = 1'b1;
      step(1);
      step(1);
      step(1);
      wait_ready();
      list_base = 32'h381; restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      step(1);
      wait_ready();
      @(negedge clk);
      chk(dq.size() == 0, "R7 all descriptors seen", dq.size(), 32'h0);
      chk(nq.size() == 0, "R7 all advances seen", nq.size(), 32'h0);
      enable = 1'b0;
      @(negedge clk);
      summary();
      $finish;
   end
endmodule